// File: doc/BRIEF.md
# Shared-Period Multi-Channel PWM Controller

This block generates several pulse-width-modulated outputs that all run on one common period. A single 8-bit prescaler divides the input clock into a local tick, and a free-running 8-bit counter on that tick forms a period that is always 256 local cycles long. Each channel compares the counter against its own 8-bit duty value. The output is high from the start of the period for as long as the counter is no greater than that value.

Software sets up the block through a small word-addressed register bus. The bus holds one duty register per channel, a control word and an interrupt-enable storage bit. The control word carries the shared enable and the prescale value. The prescale value is split into two 4-bit fields that are not next to each other. New duty and prescale values are staged and only reach the comparators when the counter wraps, so a period is never cut short or stretched in the middle.

Top module: `pwm_multi`

## Requirements
- R1: Channel c has its duty register at byte address 4*c. A write stores bits 7..0 of the write data. A read returns the stored value in bits 7..0, with bits 31..8 zero.
- R2: The control word is at byte address 0x50. Prescale bits 3..0 are in bits 3..0, prescale bits 7..4 are in bits 14..11, and the shared enable is bit 9. All other bits read as zero, so writing all ones reads back 0x00007A0F.
- R3: Bit 0 at byte address 0x54 is an interrupt-enable bit that is stored and read back only. It has no effect on the outputs, and bits 31..1 at that address read as zero.
- R4: With prescale value P, one local cycle lasts P+1 input clocks. The counter advances by exactly one per local cycle, so a period lasts 256*(P+1) input clocks.
- R5: A channel with duty value N is high for the first N+1 local cycles of each period, that is while the counter is at most N, and low for the rest of the period.
- R6: A duty value of 255 keeps the channel output high through every cycle of the period, with no low phase.
- R7: While the block is enabled, duty and prescale writes do not take effect until the counter wraps from 255 to 0. The rest of the current period runs on the old values.
- R8: While the enable bit is clear, the counter and the divider are held at zero, every output is low, and the staged values are copied through continuously. A period therefore starts from counter 0 on the first input clock after the enable is set.
- R9: Reads of duty addresses above the last channel, and of any other unmapped address, return zero. Writes to those addresses change nothing that can be read back.
- R10: After reset all registers read zero and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWe | input | 1 | Write strobe, sampled on the rising clock edge |
| busAddr | input | ADDR_W | Byte address, word aligned |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| pwmOut | output | NUM_CH | Channel outputs |

## Verification
A table of configurations drives all four channels at once. Each configuration mixes duty values 0, 1, 254, 255 and mid-range values with prescale values 0 to 3, plus one value that sets only the upper prescale field. The high time and period are counted in input clocks, so an off-by-one in the comparator, an error in the divider length or a swapped prescale field each give a different count. A duty write in the middle of a period shows whether staging holds the old value until the wrap. Readback patterns of all ones show the field masking, the ignored addresses and the interrupt-enable storage.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef struct packed {
    logic       enable;
    logic [7:0] prescale;
  } pwmCfg_t;

  localparam logic [7:0] CTRL_OFFS = 8'h50;
  localparam logic [7:0] IRQ_OFFS  = 8'h54;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWe,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  output pwmCfg_t             cfg,
  output logic [NUM_CH*8-1:0] dutyFlat,
  output logic                irqEn
);
  localparam int WORD_W = ADDR_W - 2;

  logic [NUM_CH-1:0][7:0] dutyQ;
  logic [7:0]             preQ;
  logic                   enQ;
  logic                   aligned;
  logic                   ctrlHit;
  logic                   irqHit;
  logic [WORD_W-1:0]      wordIdx;

  assign aligned = (busAddr[1:0] == 2'b00);
  assign wordIdx = busAddr[ADDR_W-1:2];
  assign ctrlHit = (busAddr == ADDR_W'(CTRL_OFFS));
  assign irqHit  = (busAddr == ADDR_W'(IRQ_OFFS));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_duty
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) dutyQ[c] <= '0;
      else if (busWe && aligned && wordIdx == WORD_W'(c)) dutyQ[c] <= busWdata[7:0];
    end
    assign dutyFlat[c*8 +: 8] = dutyQ[c];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preQ  <= '0;
      enQ   <= 1'b0;
      irqEn <= 1'b0;
    end else if (busWe) begin
      if (ctrlHit) begin
        preQ <= {busWdata[14:11], busWdata[3:0]};
        enQ  <= busWdata[9];
      end
      if (irqHit) irqEn <= busWdata[0];
    end
  end

  always_comb begin
    busRdata = '0;
    if (ctrlHit) begin
      busRdata[3:0]   = preQ[3:0];
      busRdata[14:11] = preQ[7:4];
      busRdata[9]     = enQ;
    end else if (irqHit) begin
      busRdata[0] = irqEn;
    end else if (aligned) begin
      for (int c = 0; c < NUM_CH; c++)
        if (wordIdx == WORD_W'(c)) busRdata[7:0] = dutyQ[c];
    end
  end

  assign cfg.enable   = enQ;
  assign cfg.prescale = preQ;
endmodule

// File: rtl/pwm_core.sv
module pwm_core
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  pwmCfg_t             cfg,
  input  logic [NUM_CH*8-1:0] dutyFlat,
  output logic [NUM_CH-1:0]   pwmOut,
  output logic [7:0]          cntVal,
  output logic                periodEnd,
  output logic [NUM_CH*8-1:0] dutyAct
);
  logic [7:0] divCnt;
  logic [7:0] preAct;
  logic       tick;
  logic       load;

  assign tick      = (divCnt == preAct);
  assign periodEnd = cfg.enable && tick && (cntVal == 8'hFF);
  assign load      = !cfg.enable || periodEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      cntVal <= '0;
    end else if (!cfg.enable) begin
      divCnt <= '0;
      cntVal <= '0;
    end else if (tick) begin
      divCnt <= '0;
      cntVal <= cntVal + 8'd1;
    end else begin
      divCnt <= divCnt + 8'd1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preAct  <= '0;
      dutyAct <= '0;
    end else if (load) begin
      preAct  <= cfg.prescale;
      dutyAct <= dutyFlat;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
    assign pwmOut[c] = cfg.enable && (cntVal <= dutyAct[c*8 +: 8]);
  end
endmodule

// File: rtl/pwm_multi.sv
module pwm_multi
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic [NUM_CH-1:0] pwmOut
);
  pwmCfg_t             cfg;
  logic [NUM_CH*8-1:0] dutyFlat;
  logic [NUM_CH*8-1:0] dutyAct;
  logic                irqEn;
  logic [7:0]          cntVal;
  logic                periodEnd;

  pwm_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .cfg(cfg),
    .dutyFlat(dutyFlat), .irqEn(irqEn)
  );

  pwm_core #(.NUM_CH(NUM_CH)) u_core (
    .clk(clk), .rstN(rstN), .cfg(cfg), .dutyFlat(dutyFlat),
    .pwmOut(pwmOut), .cntVal(cntVal), .periodEnd(periodEnd), .dutyAct(dutyAct)
  );
endmodule

// File: rtl/pwm_multi_chk.sv
module pwm_multi_chk #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                enable,
  input logic [7:0]          cntVal,
  input logic                periodEnd,
  input logic [NUM_CH*8-1:0] dutyAct,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [31:0]         busRdata,
  input logic [NUM_CH-1:0]   pwmOut
);
  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (pwmOut == '0)); // R8
  AST_START_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (enable && cntVal == 8'd0) |-> (&pwmOut)); // R5
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable)) |-> (cntVal == $past(cntVal) || cntVal == $past(cntVal) + 8'd1)); // R4
  AST_HOLD_DUTY: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !periodEnd) |=> $stable(dutyAct)); // R7
  AST_CTRL_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(8'h50)) |-> ((busRdata & ~32'h00007A0F) == 32'd0)); // R2
endmodule

bind pwm_multi pwm_multi_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .enable(cfg.enable), .cntVal(cntVal),
  .periodEnd(periodEnd), .dutyAct(dutyAct), .busAddr(busAddr),
  .busRdata(busRdata), .pwmOut(pwmOut)
);

// File: tb/pwm_multi_tb.sv
module pwm_multi_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int NROWS = 5;
  localparam logic [31:0] CTRL_V [NROWS] = '{32'h0000, 32'h0001, 32'h0003, 32'h0800, 32'h0002};
  localparam logic [31:0] DUTY_V [NROWS] = '{32'h017FFF00, 32'hFF00140A, 32'hFE4003C8, 32'h80FF0500, 32'hFA116321};

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWe = 1'b0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [NCH-1:0] pwmOut;
  int total = 0;
  int bad = 0;

  pwm_multi u_dut (.clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pwmOut(pwmOut));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    int hi [NCH];
    int cntHi;
    int p;
    #(CLK_PERIOD*2 + 1);
    // R10: reset state
    check("R10 out", int'(pwmOut), 0);
    rd(8'h50, r); check("R10 ctrl", int'(r), 0);
    rd(8'h00, r); check("R10 duty", int'(r), 0);
    rstN = 1'b1;

    // Table of configurations; R4 R5 R6
    for (int row = 0; row < NROWS; row++) begin
      wr(8'h50, CTRL_V[row]);
      for (int c = 0; c < NCH; c++) wr(8'(4*c), {24'h0, DUTY_V[row][8*c +: 8]});
      p = int'({CTRL_V[row][14:11], CTRL_V[row][3:0]});
      wr(8'h50, CTRL_V[row] | 32'h200);
      for (int c = 0; c < NCH; c++) hi[c] = 0;
      for (int k = 0; k < 256*(p+1); k++) begin
        for (int c = 0; c < NCH; c++) if (pwmOut[c]) hi[c]++;
        @(negedge clk);
      end
      for (int c = 0; c < NCH; c++) begin
        if (DUTY_V[row][8*c +: 8] == 8'hFF)
          check("R6 full high", hi[c], 256*(p+1));
        else
          check("R5/R4 high time", hi[c], (int'(DUTY_V[row][8*c +: 8]) + 1) * (p+1));
      end
      // period repeats: counter back at 0, all high at start
      check("R4 wrap", int'(pwmOut), 15);
      wr(8'h50, 32'h0);
      check("R8 off low", int'(pwmOut), 0);
    end

    // R7: mid-period duty change waits for wrap
    wr(8'h00, 32'd10);
    wr(8'h50, 32'h200);
    repeat (50) @(negedge clk);
    wr(8'h00, 32'd100);
    cntHi = 0;
    for (int k = 0; k < 204; k++) begin
      if (pwmOut[0]) cntHi++;
      @(negedge clk);
    end
    check("R7 old duty kept", cntHi, 0);
    cntHi = 0;
    for (int k = 0; k < 256; k++) begin
      if (pwmOut[0]) cntHi++;
      @(negedge clk);
    end
    check("R7 new duty", cntHi, 101);

    // R8: disable holds outputs low
    wr(8'h00, 32'd255);
    wr(8'h50, 32'h0);
    cntHi = 0;
    for (int k = 0; k < 600; k++) begin
      if (pwmOut != '0) cntHi++;
      @(negedge clk);
    end
    check("R8 disabled stays low", cntHi, 0);

    // R1 R2 R3 R9 readback
    wr(8'h04, 32'h000001AB);
    rd(8'h04, r); check("R1 duty readback", int'(r), 32'hAB);
    wr(8'h50, 32'hFFFFFFFF);
    rd(8'h50, r); check("R2 ctrl mask", int'(r), 32'h7A0F);
    wr(8'h50, 32'h0);
    wr(8'h54, 32'hFFFFFFFF);
    rd(8'h54, r); check("R3 irq bit", int'(r), 1);
    check("R3 no output effect", int'(pwmOut), 0);
    wr(8'h10, 32'h55);
    rd(8'h10, r); check("R9 beyond channels", int'(r), 0);
    wr(8'h40, 32'hFFFFFFFF);
    rd(8'h40, r); check("R9 unmapped", int'(r), 0);
    rd(8'h00, r); check("R9 duty0 untouched", int'(r), 255);
    rd(8'h04, r); check("R9 duty1 untouched", int'(r), 32'hAB);

    finish_run();
  end
endmodule